// File: doc/BRIEF.md
# Pending Interrupt Best-Candidate Selector

This block walks the per-line state of the shared peripheral interrupts one line per clock. For every target CPU it finds the one interrupt that CPU should be offered next. Each line carries five inputs: a pending bit, an enable bit, an active bit, a one-bit group and an 8-bit priority. It also carries a routing index that names the target CPU. Two group-enable bits gate the two groups as a whole.

A scan runs when a start pulse arrives or when any of those inputs differ from their values in the previous cycle. If an input changes while a scan is in progress, the scan begins again from the first shared line. This keeps every published result consistent with one stable set of inputs. At the end of a scan the per-target results (ID, priority and group) are replaced in a single cycle, and a one-cycle done strobe is raised in that same cycle. The results then hold until the next completed scan.

Top module: `hppi_scanner`

## Requirements
- R1: While reset is asserted and after it is released, every target reports ID 1023, priority 0xFF and group 0, and the done strobe is low.
- R2: Only lines 32 to NUM_LINES-1 take part in a scan. Lines 0 to 31 never appear as a result, whatever their state.
- R3: A line is a candidate only when it is pending, enabled and not active, and the group-enable bit for its group is set (bit 0 for group 0, bit 1 for group 1).
- R4: Among the candidates routed to one target, the one with the numerically smallest priority value is reported.
- R5: When candidates for one target share the same priority value, the one with the lower interrupt ID is reported.
- R6: Each line competes only for the target whose index its routing field holds. A routing index of NUM_TGT or more removes the line from selection.
- R7: A target with no candidate reports ID 1023, priority 0xFF and group 0 after the scan.
- R8: When a start pulse is sampled on a clock edge and the inputs then stay stable, done is high for exactly one cycle, after the (NUM_LINES-32)th following edge.
- R9: The per-target outputs change only on the edge that raises done. They hold their values in every other cycle.
- R10: A change of any line input or group-enable bit, or a start pulse, restarts the scan from line 32. No done strobe follows the edge that samples a restart, and a full scan length is needed after the last restart.
- R11: The reported group for a target is the group bit of the interrupt it reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_start_i | input | 1 | Pulse that requests a fresh scan |
| pend_i | input | NUM_LINES | Pending bit per line |
| enab_i | input | NUM_LINES | Enable bit per line |
| actv_i | input | NUM_LINES | Active bit per line |
| grp_i | input | NUM_LINES | Group bit per line |
| prio_i | input | NUM_LINES*8 | Priority per line, line n in bits [8n+7:8n] |
| route_i | input | NUM_LINES*RT_W | Target index per line, line n in bits [RT_W*n+RT_W-1:RT_W*n] |
| grp_en_i | input | 2 | Enable for group 0 (bit 0) and group 1 (bit 1) |
| done_o | output | 1 | One-cycle strobe, results just updated |
| best_id_o | output | NUM_TGT*10 | Reported interrupt ID per target, target t in bits [10t+9:10t] |
| best_prio_o | output | NUM_TGT*8 | Reported priority per target |
| best_grp_o | output | NUM_TGT | Reported group per target |

## Verification
The assertions take for granted that NUM_LINES is larger than 32 and that the scan is long enough for a done strobe and a start pulse never to fall on adjacent edges. The stimulus uses the default of 64 lines, which gives a 32-cycle scan. Inputs change only at falling clock edges or a few nanoseconds after a rising edge, never on the rising edge itself. Each change is either left in place until the resulting scan completes or deliberately made partway through a scan to test the restart rule. The bench's reference model repeats the change detection one cycle at a time, so every restart is predicted exactly.

// File: rtl/hppi_pkg.sv
package hppi_pkg;

    localparam int PRIO_W    = 8;
    localparam int ID_W      = 10;
    localparam int FIRST_SPI = 32;

    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;
    localparam logic [ID_W-1:0]   NO_ID     = 10'd1023;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic              grp;
    } best_t;

    localparam best_t EMPTY_ENTRY = '{id: NO_ID, prio: IDLE_PRIO, grp: 1'b0};

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/hppi_change_det.sv
module hppi_change_det #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] vec_i,
    output logic         changed_o
);

    logic [W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = vec_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            snap_q <= '0;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign changed_o = (vec_i != snap_q);

endmodule

// File: rtl/hppi_line_sel.sv
module hppi_line_sel
    import hppi_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_TGT   = 4,
    parameter int RT_W      = 3,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [NUM_LINES-1:0]      pend_i,
    input  logic [NUM_LINES-1:0]      enab_i,
    input  logic [NUM_LINES-1:0]      actv_i,
    input  logic [NUM_LINES-1:0]      grp_i,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
    input  logic [NUM_LINES*RT_W-1:0] route_i,
    input  logic [1:0]                grp_en_i,
    output logic                      hit_o,
    output logic [PRIO_W-1:0]         prio_o,
    output logic                      grp_o,
    output logic [RT_W-1:0]           tgt_o
);

    localparam logic [RT_W:0] TGT_LIM = (RT_W+1)'(NUM_TGT);

    logic routable;
    logic group_on;

    always_comb begin
        tgt_o    = route_i[int'(idx_i)*RT_W +: RT_W];
        prio_o   = prio_i[int'(idx_i)*PRIO_W +: PRIO_W];
        grp_o    = grp_i[idx_i];
        routable = ({1'b0, tgt_o} < TGT_LIM);
        group_on = grp_en_i[grp_o];
        hit_o    = pend_i[idx_i] & enab_i[idx_i] & ~actv_i[idx_i]
                 & group_on & routable;
    end

endmodule

// File: rtl/hppi_scanner.sv
module hppi_scanner
    import hppi_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_TGT   = 4,
    parameter int RT_W      = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        scan_start_i,
    input  logic [NUM_LINES-1:0]        pend_i,
    input  logic [NUM_LINES-1:0]        enab_i,
    input  logic [NUM_LINES-1:0]        actv_i,
    input  logic [NUM_LINES-1:0]        grp_i,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
    input  logic [NUM_LINES*RT_W-1:0]   route_i,
    input  logic [1:0]                  grp_en_i,
    output logic                        done_o,
    output logic [NUM_TGT*ID_W-1:0]     best_id_o,
    output logic [NUM_TGT*PRIO_W-1:0]   best_prio_o,
    output logic [NUM_TGT-1:0]          best_grp_o
);

    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int SNAP_W = NUM_LINES * (4 + PRIO_W + RT_W) + 2;
    localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(FIRST_SPI);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        scan_state_e              st;
        logic [IDX_W-1:0]         cur;
        best_t [NUM_TGT-1:0]      work;
        best_t [NUM_TGT-1:0]      res;
        logic                     done;
    } ctl_t;

    ctl_t d, q;

    logic              inputs_changed;
    logic              restart;
    logic              cand_hit;
    logic [PRIO_W-1:0] cand_prio;
    logic              cand_grp;
    logic [RT_W-1:0]   cand_tgt;
    best_t [NUM_TGT-1:0] merged;

    hppi_change_det #(
        .W (SNAP_W)
    ) u_change (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .vec_i     ({pend_i, enab_i, actv_i, grp_i, prio_i, route_i, grp_en_i}),
        .changed_o (inputs_changed)
    );

    hppi_line_sel #(
        .NUM_LINES (NUM_LINES),
        .NUM_TGT   (NUM_TGT),
        .RT_W      (RT_W),
        .IDX_W     (IDX_W)
    ) u_sel (
        .idx_i    (q.cur),
        .pend_i   (pend_i),
        .enab_i   (enab_i),
        .actv_i   (actv_i),
        .grp_i    (grp_i),
        .prio_i   (prio_i),
        .route_i  (route_i),
        .grp_en_i (grp_en_i),
        .hit_o    (cand_hit),
        .prio_o   (cand_prio),
        .grp_o    (cand_grp),
        .tgt_o    (cand_tgt)
    );

    assign restart = scan_start_i | inputs_changed;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        merged = q.work;

        for (int t = 0; t < NUM_TGT; t++) begin
            if (cand_hit && (cand_tgt == RT_W'(t))) begin
                if ((cand_prio < q.work[t].prio) ||
                    ((cand_prio == q.work[t].prio) && (ID_W'(q.cur) < q.work[t].id))) begin
                    merged[t] = '{id: ID_W'(q.cur), prio: cand_prio, grp: cand_grp};
                end
            end
        end

        if (restart) begin
            d.st  = ST_SCAN;
            d.cur = FIRST_IDX;
            for (int t = 0; t < NUM_TGT; t++) begin
                d.work[t] = EMPTY_ENTRY;
            end
        end else if (q.st == ST_SCAN) begin
            d.work = merged;
            if (q.cur == LAST_IDX) begin
                d.res  = merged;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end else begin
                d.cur = q.cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.st   <= ST_IDLE;
            q.cur  <= FIRST_IDX;
            q.done <= 1'b0;
            for (int t = 0; t < NUM_TGT; t++) begin
                q.work[t] <= EMPTY_ENTRY;
                q.res[t]  <= EMPTY_ENTRY;
            end
        end else begin
            q <= d;
        end
    end

    assign done_o = q.done;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_out
        assign best_id_o[t*ID_W +: ID_W]       = q.res[t].id;
        assign best_prio_o[t*PRIO_W +: PRIO_W] = q.res[t].prio;
        assign best_grp_o[t]                   = q.res[t].grp;
    end

endmodule

// File: rtl/hppi_scanner_chk.sv
module hppi_scanner_chk
    import hppi_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_TGT   = 4
) (
    input logic                      clk_i,
    input logic                      rst_ni,
    input logic                      scan_start_i,
    input logic                      done_o,
    input logic [NUM_TGT*ID_W-1:0]   best_id_o,
    input logic [NUM_TGT*PRIO_W-1:0] best_prio_o,
    input logic [NUM_TGT-1:0]        best_grp_o
);

    localparam logic [ID_W-1:0] LO_ID  = ID_W'(FIRST_SPI);
    localparam logic [ID_W-1:0] END_ID = ID_W'(NUM_LINES);

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);  // R8

    AST_START_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_start_i |=> !done_o);  // R10

    AST_HOLD_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(best_id_o) && $stable(best_prio_o) && $stable(best_grp_o)));  // R9

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        AST_EMPTY_SENTINEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (best_id_o[t*ID_W +: ID_W] == NO_ID) |->
            ((best_prio_o[t*PRIO_W +: PRIO_W] == IDLE_PRIO) && !best_grp_o[t]));  // R7

        AST_ID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (best_id_o[t*ID_W +: ID_W] != NO_ID) |->
            ((best_id_o[t*ID_W +: ID_W] >= LO_ID) && (best_id_o[t*ID_W +: ID_W] < END_ID)));  // R2
    end

endmodule

bind hppi_scanner hppi_scanner_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_TGT   (NUM_TGT)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .scan_start_i (scan_start_i),
    .done_o       (done_o),
    .best_id_o    (best_id_o),
    .best_prio_o  (best_prio_o),
    .best_grp_o   (best_grp_o)
);

// File: tb/hppi_scanner_tb.sv
module hppi_scanner_tb;

    localparam int NL   = 64;
    localparam int NT   = 4;
    localparam int RW   = 3;
    localparam int PW   = 8;
    localparam int IW   = 10;
    localparam int SCAN = NL - 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NL-1:0] pend = '0, enab = '0, actv = '0, grp = '0;
    logic [NL*PW-1:0] prio = '0;
    logic [NL*RW-1:0] route = '0;
    logic [1:0] grp_en = 2'b00;

    logic done;
    logic [NT*IW-1:0] best_id;
    logic [NT*PW-1:0] best_prio;
    logic [NT-1:0] best_grp;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hppi_scanner #(.NUM_LINES(NL), .NUM_TGT(NT), .RT_W(RW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .scan_start_i(start),
        .pend_i(pend), .enab_i(enab), .actv_i(actv), .grp_i(grp),
        .prio_i(prio), .route_i(route), .grp_en_i(grp_en),
        .done_o(done), .best_id_o(best_id), .best_prio_o(best_prio),
        .best_grp_o(best_grp)
    );

    // Behavioural reference model, updated on every rising edge.
    logic [NL*(4+PW+RW)+1:0] m_prev;
    bit m_scan, m_done;
    int m_left;
    int m_id[NT], m_pr[NT], m_g[NT];

    task automatic model_result();
        for (int t = 0; t < NT; t++) begin
            m_id[t] = 1023; m_pr[t] = 255; m_g[t] = 0;
            for (int n = 32; n < NL; n++) begin
                int pr = prio[n*PW +: PW];
                int rt = route[n*RW +: RW];
                if (pend[n] && enab[n] && !actv[n] && grp_en[grp[n]] && rt < NT && rt == t) begin
                    if (pr < m_pr[t] || (pr == m_pr[t] && n < m_id[t])) begin
                        m_id[t] = n; m_pr[t] = pr; m_g[t] = grp[n];
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        logic [NL*(4+PW+RW)+1:0] now_in;
        bit bad;
        now_in = {pend, enab, actv, grp, prio, route, grp_en};
        if (!rst_n) begin
            m_prev = '0; m_scan = 0; m_done = 0; m_left = 0;
            for (int t = 0; t < NT; t++) begin m_id[t] = 1023; m_pr[t] = 255; m_g[t] = 0; end
        end else begin
            if (start || now_in != m_prev) begin
                m_scan = 1; m_left = SCAN; m_done = 0;
            end else if (m_scan) begin
                m_left--;
                if (m_left == 0) begin model_result(); m_done = 1; m_scan = 0; end
                else m_done = 0;
            end else m_done = 0;
            m_prev = now_in;
        end
        #3;
        bad = (done !== m_done);
        for (int t = 0; t < NT; t++)
            if (best_id[t*IW +: IW] !== m_id[t] || best_prio[t*PW +: PW] !== m_pr[t] || best_grp[t] !== m_g[t])
                bad = 1;
        n_chk++;
        if (bad) begin
            n_fail++;
            $display("FAIL R9 model compare t=%0t: done=%0b exp %0b, t0 id=%0d prio=%0h exp id=%0d prio=%0h",
                     $time, done, m_done, best_id[IW-1:0], best_prio[PW-1:0], m_id[0], m_pr[0]);
        end
    end

    task automatic set_line(int n, bit p, bit e, bit a, bit g, int pr, int rt);
        pend[n] = p; enab[n] = e; actv[n] = a; grp[n] = g;
        prio[n*PW +: PW] = pr[PW-1:0];
        route[n*RW +: RW] = rt[RW-1:0];
    endtask

    task automatic clear_all();
        pend = '0; enab = '0; actv = '0; grp = '0; prio = '0; route = '0;
        grp_en = 2'b11;
    endtask

    task automatic wait_done(string req);
        bit seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); #3;
            if (done) begin seen = 1; break; end
        end
        n_chk++;
        if (!seen) begin
            n_fail++;
            $display("FAIL %s no done strobe: got 0, expected 1", req);
        end
        @(negedge clk);
    endtask

    task automatic expect_tgt(int t, int id, int pr, int g, string req);
        n_chk++;
        if (best_id[t*IW +: IW] !== id || best_prio[t*PW +: PW] !== pr || best_grp[t] !== g) begin
            n_fail++;
            $display("FAIL %s target %0d: got id=%0d prio=%0h grp=%0b, expected id=%0d prio=%0h grp=%0d",
                     req, t, best_id[t*IW +: IW], best_prio[t*PW +: PW], best_grp[t], id, pr, g);
        end
    endtask

    task automatic expect_int(int got, int exp, string req);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d, expected %0d", req, got, exp);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: got hang, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        for (int t = 0; t < NT; t++) expect_tgt(t, 1023, 255, 0, "R1 in reset");
        expect_int(done, 0, "R1 done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < NT; t++) expect_tgt(t, 1023, 255, 0, "R1 after reset");

        // R4 / R10: a lower value wins; the change alone starts a scan
        clear_all();
        set_line(40, 1, 1, 0, 0, 'h80, 0);
        set_line(45, 1, 1, 0, 0, 'h40, 0);
        wait_done("R10 auto scan");
        expect_tgt(0, 45, 'h40, 0, "R4 lower value wins");
        for (int t = 1; t < NT; t++) expect_tgt(t, 1023, 255, 0, "R7 empty target");

        // R3: active line excluded
        actv[45] = 1'b1;
        wait_done("R3");
        expect_tgt(0, 40, 'h80, 0, "R3 active excluded");

        // R3: disabled group and disabled line excluded
        grp[40] = 1'b1; grp_en = 2'b01;
        set_line(47, 1, 0, 0, 0, 0, 0);
        wait_done("R3");
        expect_tgt(0, 1023, 255, 0, "R3 group and enable gating");
        grp_en = 2'b11;
        wait_done("R11");
        expect_tgt(0, 40, 'h80, 1, "R11 group reported");

        // R5: tie goes to lower ID
        clear_all();
        set_line(60, 1, 1, 0, 0, 'h20, 1);
        set_line(50, 1, 1, 0, 1, 'h20, 1);
        set_line(55, 1, 1, 0, 0, 'h21, 1);
        wait_done("R5");
        expect_tgt(1, 50, 'h20, 1, "R5 tie to lower id");

        // R6: routing per target, out-of-range index excluded
        clear_all();
        set_line(33, 1, 1, 0, 0, 'h10, 2);
        set_line(34, 1, 1, 0, 0, 'h00, 5);
        set_line(35, 1, 1, 0, 0, 'h30, 3);
        wait_done("R6");
        expect_tgt(2, 33, 'h10, 0, "R6 routed target");
        expect_tgt(3, 35, 'h30, 0, "R6 separate target");
        expect_tgt(0, 1023, 255, 0, "R6 out-of-range route ignored");
        expect_tgt(1, 1023, 255, 0, "R7 empty target");

        // R2: lines below 32 never selected; top line included
        clear_all();
        for (int k = 0; k < 32; k++) set_line(k, 1, 1, 0, 0, 0, 0);
        set_line(63, 1, 1, 0, 0, 'hFE, 3);
        wait_done("R2");
        expect_tgt(0, 1023, 255, 0, "R2 low lines ignored");
        expect_tgt(3, 63, 'hFE, 0, "R2 last line scanned");

        // R8: start pulse, scan length
        @(negedge clk); start = 1'b1;
        @(posedge clk); #3; start = 1'b0;
        n = 0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #3; n++;
            if (done) break;
        end
        expect_int(n, SCAN, "R8 edges from start to done");
        @(posedge clk); #3;
        expect_int(done, 0, "R8 done lasts one cycle");

        // R10 / R9: change mid-scan restarts; outputs hold meanwhile
        @(negedge clk); start = 1'b1;
        @(posedge clk); #3; start = 1'b0;
        n = 0;
        repeat (10) begin @(posedge clk); #3; n++; end
        prio[63*PW +: PW] = 8'h11;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #3; n++;
            if (n == 11) expect_tgt(3, 63, 'hFE, 0, "R9 outputs held during scan");
            if (done) break;
        end
        expect_int(n, 11 + SCAN, "R10 restart delays done");
        expect_tgt(3, 63, 'h11, 0, "R10 result after restart");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule